// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block sits behind an external dual-modulus prescaler and is clocked by the prescaler's output. It divides that clock by a programmable count N. During the first A output pulses of every cycle it asks the prescaler to divide by P+1, and for the remaining N−A pulses it asks for division by P. Each full cycle of the divider therefore spans P·N + A input periods of the prescaler. With the reference divided by R, the loop settles where the VCO frequency is (P·N + A)·fref/R.

The divider takes the main count N (11 bits), the swallow count A (7 bits), a prescaler-pair select bit and an enable. It samples all three settings only at a cycle boundary, so a ratio can change at any time without causing a short or long cycle. For each cycle it produces a modulus-control level and a one-clock terminal pulse, and it passes on the registered pair select that the prescaler should use for that cycle. The block does not care which prescaler pair is in use, because it counts prescaler output pulses and not VCO periods.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_ni is low, mod_ctl_o, div_o and band_sel_o are all 0.
- R2: After any clock edge at which en_i is low, mod_ctl_o and div_o are 0. Nothing is loaded while the block is disabled.
- R3: A load happens at the first edge with en_i high after a disabled period, and at the edge that ends each cycle. Counting the clock after a load as position 0, div_o is 1 only at position N−1. This gives exactly one single-clock pulse every N clocks.
- R4: mod_ctl_o is 1 at positions 0 through A−1 and 0 at positions A through N−1.
- R5: When the loaded swallow count is 0, mod_ctl_o stays 0 for the whole cycle.
- R6: If n_i, a_i or band_sel_i change in the middle of a cycle, the current cycle is unaffected. The new values take effect from the next load.
- R7: An n_i value below 3 is loaded as 3.
- R8: An a_i value that is not below the effective N is loaded as N−1, so modulus control always drops before the terminal pulse.
- R9: band_sel_o changes only at a load, where it takes the value of band_sel_i. It is 1 when the higher pair (2P/2P+1) is used and 0 when the base pair (P/P+1) is used.
- R10: Summed over one cycle, the prescaler input periods (P+1 for each position with mod_ctl_o high, P for the others) equal P·N + A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable |
| n_i | input | 11 | Main count N |
| a_i | input | 7 | Swallow count A |
| band_sel_i | input | 1 | Prescaler pair select, sampled at load |
| mod_ctl_o | output | 1 | 1 = prescaler divides by P+1 |
| div_o | output | 1 | Terminal pulse, one clock per cycle |
| band_sel_o | output | 1 | Pair select in effect for the current cycle |

## Verification
Every output is registered state with no combinational path from any input. A setting applied before a clock edge therefore shows up in the outputs after that edge: the first load is one clock after en_i rises, and each terminal pulse comes N clocks after the load. The bench drives its inputs on falling edges. On every falling edge it compares all three outputs against a behavioural model that it updates on rising edges, so each result is checked in the cycle it is due. Period and swallow-count measurements run from pulse to pulse, and the same measurements confirm the clamps and the timing of mid-cycle changes.

// File: rtl/pulse_swallow_pkg.sv
package pulse_swallow_pkg;
  localparam int unsigned N_W   = 11;
  localparam int unsigned A_W   = 7;
  localparam int unsigned N_MIN = 3;
endpackage

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] val_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (step_i) cnt_q <= cnt_q - 1'b1;
  end

  assign tc_o = (cnt_q == '0);
endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] val_i,
  output logic         active_o
);
  logic [W-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  // saturates at zero; stays idle for the rest of the cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= val_i;
    else if (step_i && active_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pulse_swallow_pkg::*;
#(
  parameter int unsigned NW = N_W,
  parameter int unsigned AW = A_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic          band_sel_i,
  output logic          mod_ctl_o,
  output logic          div_o,
  output logic          band_sel_o
);
  localparam logic [NW-1:0] NMIN = NW'(N_MIN);

  logic          run_q, band_q;
  logic          tc, swl_active, load, step;
  logic [NW-1:0] n_eff, a_wide, a_eff;

  // ratio legalisation
  always_comb begin
    n_eff  = (n_i < NMIN) ? NMIN : n_i;
    a_wide = NW'(a_i);
    a_eff  = (a_wide >= n_eff) ? (n_eff - 1'b1) : a_wide;
  end

  assign load = en_i & (~run_q | tc);
  assign step = en_i & run_q & ~tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      band_q <= 1'b0;
    end else begin
      run_q <= en_i;
      if (load) band_q <= band_sel_i;
    end
  end

  psd_main_cnt #(.W(NW)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .val_i  (n_eff - 1'b1),
    .tc_o   (tc)
  );

  psd_swallow_cnt #(.W(AW)) u_swallow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .val_i    (a_eff[AW-1:0]),
    .active_o (swl_active)
  );

  assign mod_ctl_o  = run_q & swl_active;
  assign div_o      = run_q & tc;
  assign band_sel_o = band_q;
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic run_q,
  input logic band_sel_i,
  input logic mod_ctl_o,
  input logic div_o,
  input logic band_sel_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!mod_ctl_o && !div_o && !band_sel_o)
        else $error("R1 outputs active in reset");
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mod_ctl_o && !div_o));

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  a_r8_mod_low_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> !mod_ctl_o);

  a_r4_no_reassert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !mod_ctl_o && !div_o) |=> !mod_ctl_o);

  a_r9_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && (!run_q || div_o)) |=> $stable(band_sel_o));

  a_r9_band_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (!run_q || div_o)) |=> (band_sel_o == $past(band_sel_i)));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .run_q      (run_q),
  .band_sel_i (band_sel_i),
  .mod_ctl_o  (mod_ctl_o),
  .div_o      (div_o),
  .band_sel_o (band_sel_o)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;
  localparam int P_BASE = 32;
  localparam int WDOG   = 30000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [10:0] n_in = 11'd5;
  logic [6:0]  a_in = 7'd2;
  logic        band_in = 1'b0;
  logic        mod_ctl, div, band_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_swallow_div u_pulse_swallow_div (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .n_i(n_in), .a_i(a_in),
    .band_sel_i(band_in), .mod_ctl_o(mod_ctl), .div_o(div), .band_sel_o(band_out)
  );

  // behavioural reference
  bit m_run = 0;
  int m_pos = 0, m_n = 3, m_a = 0, m_band = 0, acc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_n = 3; m_a = 0; m_band = 0;
    end else if (!en) begin
      m_run = 0;
    end else if (!m_run || m_pos == m_n - 1) begin
      m_n    = (int'(n_in) < 3) ? 3 : int'(n_in);
      m_a    = (int'(a_in) >= m_n) ? m_n - 1 : int'(a_in);
      m_band = band_in;
      m_pos  = 0;
      m_run  = 1;
    end else begin
      m_pos++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_mod, e_div;
      int p;
      e_mod = m_run && (m_pos < m_a);
      e_div = m_run && (m_pos == m_n - 1);
      chk(mod_ctl == e_mod, !m_run ? "R2 mod" : (m_a == 0 ? "R5 mod" : "R4 mod"), mod_ctl, e_mod);
      chk(div == e_div, m_run ? "R3 div" : "R2 div", div, e_div);
      chk(band_out == m_band[0], "R9 band", band_out, m_band);
      p = m_band ? 2 * P_BASE : P_BASE;
      if (!m_run) acc = 0;
      else begin
        acc += mod_ctl ? p + 1 : p;
        if (div) begin
          chk(acc == p * m_n + m_a, "R10 total", acc, p * m_n + m_a);
          acc = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic measure(output int per, output int mods);
    do @(negedge clk); while (!div);
    per = 0; mods = 0;
    do begin
      @(negedge clk);
      per++;
      if (mod_ctl) mods++;
    end while (!div);
  endtask

  initial begin
    int per, mods;
    repeat (3) @(negedge clk);
    chk(!mod_ctl && !div && !band_out, "R1 reset", {mod_ctl, div, band_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;

    measure(per, mods);
    chk(per == 5, "R3 period", per, 5);
    chk(mods == 2, "R4 swallow", mods, 2);
    measure(per, mods);
    chk(per == 5, "R3 period", per, 5);

    n_in = 11'd9; a_in = 7'd0; band_in = 1'b1;
    measure(per, mods);
    chk(per == 9, "R3 period", per, 9);
    chk(mods == 0, "R5 zero swallow", mods, 0);
    chk(band_out == 1'b1, "R9 band", band_out, 1);

    n_in = 11'd2; a_in = 7'd1; band_in = 1'b0;
    measure(per, mods);
    chk(per == 3, "R7 min N", per, 3);
    chk(mods == 1, "R7 swallow", mods, 1);

    n_in = 11'd4; a_in = 7'd9;
    measure(per, mods);
    chk(per == 4, "R8 period", per, 4);
    chk(mods == 3, "R8 clamp", mods, 3);

    // R6: change mid-cycle
    n_in = 11'd6; a_in = 7'd1;
    do @(negedge clk); while (!div);
    do @(negedge clk); while (!div);
    @(negedge clk);
    n_in = 11'd4; a_in = 7'd3; band_in = 1'b1;
    per = 1; mods = mod_ctl ? 1 : 0;
    do begin
      @(negedge clk);
      per++;
      if (mod_ctl) mods++;
    end while (!div);
    chk(per == 6, "R6 old period", per, 6);
    chk(mods == 1, "R6 old swallow", mods, 1);
    chk(band_out == 1'b0, "R6 old band", band_out, 0);
    measure(per, mods);
    chk(per == 4 && mods == 3, "R6 new ratio", per * 100 + mods, 403);

    // R2 / R9: disabled
    en = 1'b0;
    band_in = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!mod_ctl && !div, "R2 idle", {mod_ctl, div}, 0);
      chk(band_out == 1'b1, "R9 hold while idle", band_out, 1);
    end
    n_in = 11'd2047; a_in = 7'd127;
    en = 1'b1;
    @(negedge clk);
    chk(band_out == 1'b0 && mod_ctl, "R9 load on enable", {band_out, mod_ctl}, 1);
    per = 1; mods = 1;
    do begin
      @(negedge clk);
      per++;
      if (mod_ctl) mods++;
    end while (!div);
    chk(per == 2047, "R3 max period", per, 2047);
    chk(mods == 127, "R4 max swallow", mods, 127);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule